// File: doc/BRIEF.md
# Device Interrupt Combiner with Pending-Line Vector

This block gathers fifteen level-sensitive device interrupt lines and one internal timer line and presents them to a processor as two interrupt outputs. Device lines 0 to 14 form the general group. After a per-line enable mask is applied, the group is folded onto a single general output. Line 15 belongs to an internal pending-event counter. An external periodic tick advances that counter, and the line drives a separate timer output.

Software works the block through a one-cycle register port. It has three registers. The first is a 16-bit enable mask. The second is a status word that names the lowest-numbered asserted device line. The third is a timer acknowledge register that gives back one pending timer event. The general output reacts to edges. It rises when the enabled group goes from empty to non-empty and falls when the group empties. Any status access drops it until the group empties and fills again. This lets the interrupt handler read the vector once and re-arm the line.

Top module: `irq_aggr`

## Requirements
- R1: After reset the enable mask reads 0, the pending count reads 0, and both interrupt outputs are low.
- R2: The general output goes high one clock edge after the masked set of device lines 0 to 14 changes from empty to non-empty.
- R3: The general output goes low one clock edge after the masked device set becomes empty, whether an input or a mask write emptied it.
- R4: A write to address 0 stores all 16 bits of the enable mask, and a read of address 0 returns it. Mask bits 0 to 14 gate the device lines and bit 15 gates the timer line. The new mask takes effect on the outputs at the same edge that stores it.
- R5: A read of address 1 returns (i+1)*4 for the lowest-numbered asserted raw device line i, regardless of the mask. It returns 0 when no device line is asserted.
- R6: Any access to address 1, read or write, drives the general output low at the next edge. The output stays low while the masked set stays non-empty, and it rises again only after the set empties and refills. A write to address 1 does not change the mask.
- R7: Each clock cycle with the tick input high adds one to the pending count. A read of address 2 returns the count held before that access.
- R8: The pending count saturates at 2^CNT_W-1 (15 by default) and does not wrap.
- R9: Any access to address 2 removes one pending event if the count is non-zero. A tick and an access in the same cycle leave a non-zero count unchanged.
- R10: The timer output is high when the pending count is non-zero and mask bit 15 is set. It is forced low for the one cycle that follows each access to address 2.
- R11: Address 3 reads 0, and a write to it changes neither the mask, the count, nor the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_irq_i | input | 15 | Level device interrupt lines 0..14 |
| tick_i | input | 1 | Periodic timer tick, one event per high cycle |
| req_valid_i | input | 1 | Register access strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 2 | Register select: 0 mask, 1 status, 2 timer ack, 3 spare |
| req_wdata_i | input | 16 | Write data |
| req_rdata_o | output | 16 | Read data, valid in the cycle of a read |
| gen_irq_o | output | 1 | General-group interrupt to the processor |
| tmr_irq_o | output | 1 | Timer interrupt to the processor |

## Verification
A stale copy of the previous group state shows up one edge after an input change. The general output then either misses a rising set or keeps firing after a status access, so the bench samples it exactly one edge after each stimulus. A pending count that is off by one does not show up until software drains it. The bench therefore reads the count back through the acknowledge register right after bursts, at saturation, and after a tick collides with an access. A wrong mask gate shows up on the timer output in the cycle after the mask write.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;
  localparam int unsigned REG_AW    = 2;
  localparam int unsigned VEC_SHIFT = 2;

  typedef enum logic [REG_AW-1:0] {
    REG_MASK  = 2'd0,
    REG_STAT  = 2'd1,
    REG_TACK  = 2'd2,
    REG_SPARE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N  = 15,
  parameter int unsigned VW = $clog2(N + 1)
) (
  input  logic [N-1:0]  lines_i,
  output logic [VW-1:0] vec_o
);
  // lowest set line wins: scan downward so the last hit is the smallest index
  always_comb begin
    vec_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (lines_i[i]) vec_o = VW'(i + 1);
    end
  end
endmodule

// File: rtl/irq_level_track.sv
module irq_level_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic any_i,
  input  logic clr_i,
  output logic irq_o
);
  logic any_q, irq_q;
  logic rise, fall;

  assign rise = any_i & ~any_q;
  assign fall = ~any_i & any_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      any_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      any_q <= any_i;
      if (clr_i)     irq_q <= 1'b0;
      else if (rise) irq_q <= 1'b1;
      else if (fall) irq_q <= 1'b0;
    end
  end

  assign irq_o = irq_q;

  AST_GEN_CLR_ON_STAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !irq_o); // R6
  AST_GEN_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> any_q); // R3
  AST_GEN_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && any_i && !any_q) |=> irq_o); // R2
endmodule

// File: rtl/irq_tick_cnt.sv
module irq_tick_cnt #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             ack_i,
  input  logic             en_i,
  output logic             irq_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             irq_q;

  always_comb begin
    cnt_d = cnt_q;
    unique case ({tick_i, ack_i})
      2'b10:   if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      2'b01:   if (cnt_q != '0)      cnt_d = cnt_q - 1'b1;
      2'b11:   if (cnt_q == '0)      cnt_d = CNT_W'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      irq_q <= ~ack_i & (cnt_d != '0) & en_i;
    end
  end

  assign irq_o   = irq_q;
  assign count_o = cnt_q;

  AST_CNT_SATURATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && tick_i && !ack_i) |=> cnt_q == CNT_MAX); // R8
  AST_CNT_DECREMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !tick_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1); // R9
  AST_TMR_ACK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !irq_o); // R10
  AST_TMR_NEEDS_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> cnt_q != '0); // R10
endmodule

// File: rtl/irq_aggr.sv
module irq_aggr
  import irq_aggr_pkg::*;
#(
  parameter int unsigned N_DEV = 15,
  parameter int unsigned CNT_W = 4,
  parameter int unsigned DW    = N_DEV + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_DEV-1:0]  dev_irq_i,
  input  logic              tick_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [REG_AW-1:0] req_addr_i,
  input  logic [DW-1:0]     req_wdata_i,
  output logic [DW-1:0]     req_rdata_o,
  output logic              gen_irq_o,
  output logic              tmr_irq_o
);
  localparam int unsigned VW    = $clog2(N_DEV + 1);
  localparam int unsigned TMR_B = N_DEV;

  reg_sel_e          sel;
  logic [DW-1:0]     mask_q, mask_d;
  logic              mask_wr, stat_acc, tack_acc;
  logic              gen_any;
  logic [VW-1:0]     vec;
  logic [CNT_W-1:0]  pend_cnt;

  assign sel      = reg_sel_e'(req_addr_i);
  assign mask_wr  = req_valid_i & req_write_i & (sel == REG_MASK);
  assign stat_acc = req_valid_i & (sel == REG_STAT);
  assign tack_acc = req_valid_i & (sel == REG_TACK);

  // next-value mask so a mask write moves the outputs at the same edge
  assign mask_d  = mask_wr ? req_wdata_i : mask_q;
  assign gen_any = |(dev_irq_i & mask_d[N_DEV-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= mask_d;
  end

  irq_prio_enc #(.N(N_DEV), .VW(VW)) u_enc (
    .lines_i (dev_irq_i),
    .vec_o   (vec)
  );

  irq_level_track u_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .any_i  (gen_any),
    .clr_i  (stat_acc),
    .irq_o  (gen_irq_o)
  );

  irq_tick_cnt #(.CNT_W(CNT_W)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .ack_i   (tack_acc),
    .en_i    (mask_d[TMR_B]),
    .irq_o   (tmr_irq_o),
    .count_o (pend_cnt)
  );

  always_comb begin
    req_rdata_o = '0;
    if (req_valid_i && !req_write_i) begin
      unique case (sel)
        REG_MASK: req_rdata_o = mask_q;
        REG_STAT: req_rdata_o = DW'(vec) << VEC_SHIFT;
        REG_TACK: req_rdata_o = DW'(pend_cnt);
        default:  req_rdata_o = '0;
      endcase
    end
  end

  AST_VEC_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec != '0) |-> dev_irq_i[vec - 1'b1]); // R5
  AST_VEC_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec == '0) |-> (dev_irq_i == '0)); // R5
  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_wr |=> $stable(mask_q)); // R11
  AST_TMR_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_irq_o |-> mask_q[TMR_B]); // R10
endmodule

// File: tb/irq_aggr_tb.sv
module irq_aggr_tb;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [14:0] dev_irq_i = '0;
  logic        tick_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_write_i = 1'b0;
  logic [1:0]  req_addr_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic [15:0] req_rdata_o;
  logic        gen_irq_o, tmr_irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  irq_aggr u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dev_irq_i   (dev_irq_i),
    .tick_i      (tick_i),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .req_rdata_o (req_rdata_o),
    .gen_irq_o   (gen_irq_o),
    .tmr_irq_o   (tmr_irq_o)
  );

  // {device lines, expected status word}
  localparam logic [30:0] STAT_TBL [8] = '{
    {15'h0001, 16'd4},
    {15'h0002, 16'd8},
    {15'h4000, 16'd60},
    {15'h0C00, 16'd44},
    {15'h0010, 16'd20},
    {15'h7FFF, 16'd4},
    {15'h6000, 16'd56},
    {15'h0000, 16'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [1:0] a, input logic [15:0] wd,
                     output logic [15:0] rd);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = wr; req_addr_i = a; req_wdata_i = wd;
    #1 rd = req_rdata_o;
    @(negedge clk_i);
    req_valid_i = 1'b0; req_write_i = 1'b0;
  endtask

  task automatic set_dev(input logic [14:0] v);
    @(negedge clk_i);
    dev_irq_i = v;
    @(negedge clk_i);
  endtask

  task automatic ticks(input int n);
    @(negedge clk_i);
    tick_i = 1'b1;
    repeat (n) @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  initial begin
    #(CLK_P * 50000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    chk("R1 gen", gen_irq_o, 0);
    chk("R1 tmr", tmr_irq_o, 0);
    acc(1'b0, 2'd0, 16'h0, rd); chk("R1 mask", rd, 0);
    acc(1'b0, 2'd2, 16'h0, rd); chk("R1 count", rd, 0);

    // R4 mask write/read
    acc(1'b1, 2'd0, 16'h7FFF, rd);
    acc(1'b0, 2'd0, 16'h0, rd); chk("R4 mask readback", rd, 16'h7FFF);

    // R5 status vector table
    for (int i = 0; i < 8; i++) begin
      set_dev(STAT_TBL[i][30:16]);
      acc(1'b0, 2'd1, 16'h0, rd);
      chk("R5 status", rd, STAT_TBL[i][15:0]);
    end

    // R2 / R3 edges
    set_dev(15'h0000); chk("R3 gen empty", gen_irq_o, 0);
    set_dev(15'h0100); chk("R2 gen rise", gen_irq_o, 1);
    set_dev(15'h0000); chk("R3 gen fall", gen_irq_o, 0);
    chk("R10 tmr idle", tmr_irq_o, 0);

    // R4 mask gating, same-edge effect
    set_dev(15'h0020); chk("R2 gen line5", gen_irq_o, 1);
    acc(1'b1, 2'd0, 16'h7FDF, rd); chk("R3 mask drop", gen_irq_o, 0);
    acc(1'b1, 2'd0, 16'h7FFF, rd); chk("R4 mask restore", gen_irq_o, 1);

    // R6 status access clears gen
    acc(1'b0, 2'd1, 16'h0, rd);
    chk("R5 status line5", rd, 24);
    chk("R6 gen cleared", gen_irq_o, 0);
    @(negedge clk_i); chk("R6 gen stays low", gen_irq_o, 0);
    acc(1'b1, 2'd1, 16'hFFFF, rd);
    acc(1'b0, 2'd0, 16'h0, rd); chk("R6 status write keeps mask", rd, 16'h7FFF);
    set_dev(15'h0000);
    set_dev(15'h0020); chk("R6 gen rearmed", gen_irq_o, 1);
    set_dev(15'h0000);

    // R7 / R9 / R10 timer
    acc(1'b1, 2'd0, 16'hFFFF, rd);
    chk("R10 tmr no events", tmr_irq_o, 0);
    ticks(1); chk("R10 tmr on tick", tmr_irq_o, 1);
    acc(1'b0, 2'd2, 16'h0, rd); chk("R7 count one", rd, 1);
    chk("R9 tmr after drain", tmr_irq_o, 0);
    acc(1'b0, 2'd2, 16'h0, rd); chk("R9 count zero", rd, 0);
    ticks(3); chk("R10 tmr burst", tmr_irq_o, 1);
    acc(1'b0, 2'd2, 16'h0, rd); chk("R7 count three", rd, 3);
    chk("R10 tmr low after ack", tmr_irq_o, 0);
    @(negedge clk_i); chk("R10 tmr back high", tmr_irq_o, 1);
    acc(1'b1, 2'd0, 16'h7FFF, rd); chk("R10 tmr masked", tmr_irq_o, 0);
    acc(1'b1, 2'd0, 16'hFFFF, rd); chk("R10 tmr unmasked", tmr_irq_o, 1);

    // R8 saturation (count was 2)
    ticks(20);
    acc(1'b0, 2'd2, 16'h0, rd); chk("R8 saturated", rd, 15);

    // R9 tick and ack together (count 14)
    @(negedge clk_i);
    tick_i = 1'b1; req_valid_i = 1'b1; req_write_i = 1'b0; req_addr_i = 2'd2;
    #1 rd = req_rdata_o;
    @(negedge clk_i);
    tick_i = 1'b0; req_valid_i = 1'b0;
    chk("R9 collide read", rd, 14);
    acc(1'b0, 2'd2, 16'h0, rd); chk("R9 collide count kept", rd, 14);

    // R11 spare address
    acc(1'b1, 2'd3, 16'h1234, rd);
    chk("R11 tmr unchanged", tmr_irq_o, 1);
    acc(1'b0, 2'd3, 16'h0, rd); chk("R11 spare reads zero", rd, 0);
    acc(1'b0, 2'd0, 16'h0, rd); chk("R11 mask unchanged", rd, 16'hFFFF);
    acc(1'b0, 2'd2, 16'h0, rd); chk("R11 count unchanged", rd, 13);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule